// File: doc/BRIEF.md
# Circular-Buffer Multiply-Accumulate Loop Engine

The block is a sequential dot-product engine for two arrays of signed 16-bit samples in byte-addressed, halfword-wide memory. A single start pulse loads the X base address, the Y base address, a 32-bit starting accumulator, an 8-bit iteration count, a circular buffer size code and two scaling codes. The engine then steps through the arrays on its own. Each step reads one X sample and then one Y sample through a synchronous read port, multiplies the two samples and adds the scaled product to a 48-bit accumulator.

Y is always walked linearly. X can be confined to a power-of-two buffer aligned to its own size, and it wraps inside that buffer. When the loop ends, the accumulator is shifted back down, clamped to the signed 32-bit range and presented together with the next X and Y addresses and an overflow flag. These outputs stay valid until the next start pulse. The engine is meant to run a filter tap loop over a sample ring on behalf of a host that only sees start, busy and done.

Top module: `mac_loop_engine`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o` and `mem_req_o` are low, and `result_o`, `ovf_o`, `x_next_o` and `y_next_o` are zero.
- R2: Each iteration takes three cycles in this order:
  - a read request for X;
  - a read request for Y, with the X sample returned on `mem_rdata_i` in this cycle;
  - a cycle with no request, with the Y sample returned in this cycle.
  The first request appears in the cycle after the start edge. `done_o` is a single-cycle pulse in cycle 3n+2 counted from the start edge. `busy_o` is high from cycle 1 up to and including that cycle.
- R3: A count of 0 runs 256 iterations. Any other count n runs n iterations.
- R4: The Y address of iteration i is Y base + 2·i. `y_next_o` ends at Y base + 2·n.
- R5: The X address advances by 2 after every iteration. For size code k in 1..15, the buffer is 2^k bytes: only address bits [k-1:0] advance, modulo 2^k, and the upper bits never change. Size code 0 gives linear X addressing. `x_next_o` is the address that would follow the last X read.
- R6: The accumulator is built as follows:
  - It starts at the sign-extended initial value shifted left by shift1.
  - When shift1 is nonzero, 2^(shift1-1) is added to that starting value.
  - Each signed 16x16 product is shifted left by shift2 and added modulo 2^48.
  - The final value is the accumulator shifted right arithmetically by shift1.
- R7: A final value above 2^31-1 gives `result_o` = 32'h7FFFFFFF with `ovf_o` = 1. A final value below -2^31 gives `result_o` = 32'h80000000 with `ovf_o` = 1. Any other final value is passed through with `ovf_o` = 0.
- R8: A start pulse while `busy_o` is high is ignored: the memory sequence, the result and the next addresses of the running loop are unchanged.
- R9: `result_o`, `ovf_o`, `x_next_o` and `y_next_o` hold their values after `done_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle |
| x_base_i | input | 32 | X start byte address |
| y_base_i | input | 32 | Y start byte address |
| acc_init_i | input | 32 | Signed initial accumulator |
| count_i | input | 8 | Iteration count (0 = 256) |
| size_code_i | input | 4 | X buffer size code: 0 linear, k gives 2^k bytes |
| shift1_i | input | 4 | Seed shift and final right shift |
| shift2_i | input | 4 | Product left shift |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read byte address |
| mem_rdata_i | input | 16 | Read data, one cycle after the request |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | Completion pulse |
| result_o | output | 32 | Saturated result |
| ovf_o | output | 1 | Saturation occurred |
| x_next_o | output | 32 | Next X address |
| y_next_o | output | 32 | Next Y address |

## Verification
The hardest state to reach is the end of a 256-iteration loop with large scaling codes, where the 48-bit accumulator, the rounding seed and the buffer wrap all act at once. The stimulus gets there with a count of 0, a 64-byte X ring and both shift codes at 15.

Saturation in each direction is forced from the ports by placing runs of 0x7FFF and 0x8000 in memory and seeding the accumulator at its extremes. A stray start pulse is injected in the middle of a loop, and every request address is compared cycle by cycle against a behavioural model.

// File: rtl/mac_loop_pkg.sv
package mac_loop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDX,
    ST_RDY,
    ST_MAC,
    ST_FIN,
    ST_DONE
  } mac_state_e;
endpackage

// File: rtl/mac_loop_ctrl.sv
module mac_loop_ctrl
  import mac_loop_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output mac_state_e       state_o,
  output logic             load_o
);
  localparam int CW1 = CNT_W + 1;

  mac_state_e     state_q;
  logic [CW1-1:0] cnt_q;

  assign load_o  = start_i && (state_q == ST_IDLE);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RDX;
          // zero count means full range
          cnt_q   <= (count_i == '0) ? (CW1'(1) << CNT_W) : {1'b0, count_i};
        end
        ST_RDX: state_q <= ST_RDY;
        ST_RDY: state_q <= ST_MAC;
        ST_MAC: begin
          cnt_q   <= cnt_q - 1'b1;
          state_q <= (cnt_q == CW1'(1)) ? ST_FIN : ST_RDX;
        end
        ST_FIN:  state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_cnt_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MAC) |-> (cnt_q != '0));
  assert_done_after_fin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIN) |=> (state_q == ST_DONE));
endmodule

// File: rtl/mac_addr_gen.sv
module mac_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] x_base_i,
  input  logic [AW-1:0] y_base_i,
  input  logic [CW-1:0] size_code_i,
  output logic [AW-1:0] x_o,
  output logic [AW-1:0] y_o
);
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0] x_q, y_q, mask, x_inc;
  logic [CW-1:0] size_q;

  assign mask  = (size_q == '0) ? '0 : ((AW'(1) << size_q) - AW'(1));
  assign x_inc = x_q + STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      size_q <= '0;
    end else if (load_i) begin
      x_q    <= x_base_i;
      y_q    <= y_base_i;
      size_q <= size_code_i;
    end else if (step_i) begin
      // ring: upper bits pinned, low bits wrap
      x_q <= (size_q == '0) ? x_inc : ((x_q & ~mask) | (x_inc & mask));
      y_q <= y_q + STEP;
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;

  assert_y_linear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (y_q == $past(y_q) + STEP));
  assert_x_ring_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && size_q != '0) |=> ((x_q & ~mask) == ($past(x_q) & ~mask)));
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int DW    = 16,
  parameter int ACC_W = 48,
  parameter int RW    = 32,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          x_cap_i,
  input  logic          mac_i,
  input  logic          fin_i,
  input  logic [RW-1:0] init_i,
  input  logic [CW-1:0] shift1_i,
  input  logic [CW-1:0] shift2_i,
  input  logic [DW-1:0] rdata_i,
  output logic [RW-1:0] result_o,
  output logic          ovf_o
);
  localparam int PW = 2 * DW;
  localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-RW+1){1'b0}}, {(RW-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-RW+1){1'b1}}, {(RW-1){1'b0}}};

  logic [CW-1:0]            s1_q, s2_q;
  logic [DW-1:0]            xs_q;
  logic signed [ACC_W-1:0]  acc_q, init_ext, rnd, seed, prod_ext, scaled, shifted;
  logic signed [PW-1:0]     prod;
  logic [RW-1:0]            result_q;
  logic                     ovf_q;

  assign init_ext = {{(ACC_W-RW){init_i[RW-1]}}, init_i};
  assign rnd      = (shift1_i == '0) ? '0 : (ACC_W'(1) << (shift1_i - 1'b1));
  assign seed     = (init_ext <<< shift1_i) + rnd;
  assign prod     = $signed(xs_q) * $signed(rdata_i);
  assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
  assign scaled   = prod_ext <<< s2_q;
  assign shifted  = acc_q >>> s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q     <= '0;
      s2_q     <= '0;
      xs_q     <= '0;
      acc_q    <= '0;
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (load_i) begin
        s1_q  <= shift1_i;
        s2_q  <= shift2_i;
        acc_q <= seed;
      end else if (mac_i) begin
        acc_q <= acc_q + scaled;
      end
      if (x_cap_i) xs_q <= rdata_i;
      if (fin_i) begin
        if (shifted > MAXV) begin
          result_q <= MAXV[RW-1:0];
          ovf_q    <= 1'b1;
        end else if (shifted < MINV) begin
          result_q <= MINV[RW-1:0];
          ovf_q    <= 1'b1;
        end else begin
          result_q <= shifted[RW-1:0];
          ovf_q    <= 1'b0;
        end
      end
    end
  end

  assign result_o = result_q;
  assign ovf_o    = ovf_q;

  assert_sat_extreme_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (result_q == MAXV[RW-1:0] || result_q == MINV[RW-1:0]));
  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> $stable(result_q) && $stable(ovf_q));
endmodule

// File: rtl/mac_loop_engine.sv
module mac_loop_engine
  import mac_loop_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 16,
  parameter int ACC_W = 48,
  parameter int RW    = 32,
  parameter int CNT_W = 8,
  parameter int CW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    x_base_i,
  input  logic [AW-1:0]    y_base_i,
  input  logic [RW-1:0]    acc_init_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CW-1:0]    size_code_i,
  input  logic [CW-1:0]    shift1_i,
  input  logic [CW-1:0]    shift2_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RW-1:0]    result_o,
  output logic             ovf_o,
  output logic [AW-1:0]    x_next_o,
  output logic [AW-1:0]    y_next_o
);
  mac_state_e    state;
  logic          load;
  logic [AW-1:0] x_addr, y_addr;

  mac_loop_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .count_i (count_i),
    .state_o (state),
    .load_o  (load)
  );

  mac_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .step_i      (state == ST_MAC),
    .x_base_i    (x_base_i),
    .y_base_i    (y_base_i),
    .size_code_i (size_code_i),
    .x_o         (x_addr),
    .y_o         (y_addr)
  );

  mac_datapath #(.DW(DW), .ACC_W(ACC_W), .RW(RW), .CW(CW)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .x_cap_i  (state == ST_RDY),
    .mac_i    (state == ST_MAC),
    .fin_i    (state == ST_FIN),
    .init_i   (acc_init_i),
    .shift1_i (shift1_i),
    .shift2_i (shift2_i),
    .rdata_i  (mem_rdata_i),
    .result_o (result_o),
    .ovf_o    (ovf_o)
  );

  assign mem_req_o  = (state == ST_RDX) || (state == ST_RDY);
  assign mem_addr_o = (state == ST_RDX) ? x_addr : y_addr;
  assign busy_o     = (state != ST_IDLE);
  assign done_o     = (state == ST_DONE);
  assign x_next_o   = x_addr;
  assign y_next_o   = y_addr;

  assert_req_in_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/mac_loop_engine_bench.sv
module mac_loop_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] x_base = '0, y_base = '0, acc_init = '0;
  logic [7:0]  count = '0;
  logic [3:0]  size_code = '0, sh1 = '0, sh2 = '0;
  logic        mem_req, busy, done, ovf;
  logic [31:0] mem_addr, result, x_next, y_next;
  logic [15:0] rdata = '0;
  logic [15:0] mem [0:1023];

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  mac_loop_engine u_mac_loop_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .x_base_i(x_base), .y_base_i(y_base), .acc_init_i(acc_init),
    .count_i(count), .size_code_i(size_code), .shift1_i(sh1), .shift2_i(sh2),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .result_o(result), .ovf_o(ovf),
    .x_next_o(x_next), .y_next_o(y_next)
  );

  always @(posedge clk) if (mem_req) rdata <= mem[mem_addr[10:1]];

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog: cycles=%0d expected<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nx(input logic [31:0] a, input int k);
    logic [31:0] m;
    if (k == 0) return a + 32'd2;
    m = (32'd1 << k) - 32'd1;
    return (a & ~m) | ((a + 32'd2) & m);
  endfunction

  function automatic longint wrap48(input longint v);
    return (v <<< 16) >>> 16;
  endfunction

  task automatic run(input logic [31:0] xb, input logic [31:0] yb, input logic [31:0] init,
                     input logic [7:0] cn, input int k, input int s1, input int s2, input bit stray);
    int n;
    logic [31:0] xa, ya, exp_res;
    longint acc, p, r;
    logic exp_ovf;
    logic [32:0] exp_q[$];
    n  = (cn == 0) ? 256 : int'(cn);
    xa = xb; ya = yb;
    acc = (longint'($signed(init)) <<< s1) + ((s1 == 0) ? 64'sd0 : (64'sd1 <<< (s1 - 1)));
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({1'b1, xa});
      exp_q.push_back({1'b1, ya});
      exp_q.push_back({1'b0, 32'h0});
      p = longint'($signed(mem[xa[10:1]])) * longint'($signed(mem[ya[10:1]]));
      acc = wrap48(acc + (p <<< s2));
      xa = nx(xa, k);
      ya = ya + 32'd2;
    end
    exp_q.push_back({1'b0, 32'h0});
    exp_q.push_back({1'b0, 32'h0});
    r = acc >>> s1;
    if (r > 64'sd2147483647) begin exp_res = 32'h7FFFFFFF; exp_ovf = 1'b1; end
    else if (r < -64'sd2147483648) begin exp_res = 32'h80000000; exp_ovf = 1'b1; end
    else begin exp_res = r[31:0]; exp_ovf = 1'b0; end

    @(negedge clk);
    x_base = xb; y_base = yb; acc_init = init; count = cn;
    size_code = 4'(k); sh1 = 4'(s1); sh2 = 4'(s2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 3 * n + 2; c++) begin
      logic [32:0] e;
      e = exp_q.pop_front();
      chk("R2", "busy", 32'(busy), 32'd1);
      chk("R2", "req", 32'(mem_req), 32'(e[32]));
      if (e[32]) chk("R5/R4", "addr", mem_addr, e[31:0]);
      chk("R2", "done", 32'(done), (c == 3 * n + 2) ? 32'd1 : 32'd0);
      if (stray && c == 4) begin
        // R8: stray start with different operands mid-loop
        start = 1'b1; x_base = 32'h10; y_base = 32'h20; count = 8'd1; acc_init = 32'h5;
        sh1 = 4'd2; size_code = 4'd0;
      end else begin
        start = 1'b0;
      end
      if (c != 3 * n + 2) @(negedge clk);
    end
    chk("R6/R7", "result", result, exp_res);
    chk("R7", "ovf", 32'(ovf), 32'(exp_ovf));
    chk("R5", "x_next", x_next, xa);
    chk("R4", "y_next", y_next, ya);
    repeat (3) @(negedge clk);
    chk("R2", "busy after done", 32'(busy), 32'd0);
    chk("R2", "done pulse width", 32'(done), 32'd0);
    chk("R9", "result hold", result, exp_res);
    chk("R9", "ovf hold", 32'(ovf), 32'(exp_ovf));
    chk("R9", "x_next hold", x_next, xa);
    chk("R9", "y_next hold", y_next, ya);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'((i * 7919 + 13) ^ (i << 9));
    for (int i = 0; i < 4; i++) begin
      mem[10'h300 + i] = 16'h7FFF;
      mem[10'h380 + i] = 16'h8000;
    end
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 32'(busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "req", 32'(mem_req), 32'd0);
    chk("R1", "result", result, 32'd0);
    chk("R1", "ovf", 32'(ovf), 32'd0);
    chk("R1", "x_next", x_next, 32'd0);
    chk("R1", "y_next", y_next, 32'd0);

    run(32'h100, 32'h300, 32'd123, 8'd5, 0, 0, 0, 1'b0);        // R6 linear
    run(32'h204, 32'h480, 32'hFFFF_F000, 8'd7, 3, 4, 2, 1'b0);  // R5 ring wrap
    run(32'h000, 32'h400, 32'h0001_2345, 8'd0, 6, 15, 15, 1'b0); // R3 256 iterations
    run(32'h600, 32'h600, 32'h7FFF_0000, 8'd4, 0, 0, 0, 1'b0);  // R7 high clamp
    run(32'h600, 32'h700, 32'h8000_0000, 8'd4, 0, 0, 0, 1'b0);  // R7 low clamp
    run(32'h100, 32'h300, 32'hFFFF_FFFB, 8'd1, 0, 3, 0, 1'b0);  // R6 rounding
    run(32'h120, 32'h340, 32'd77, 8'd6, 2, 1, 1, 1'b1);         // R8 stray start
    run(32'h206, 32'h500, 32'd0, 8'd3, 1, 0, 3, 1'b0);          // R5 two-byte ring

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule